// File: doc/BRIEF.md
# Configurable Carry-Save Cipher Cluster

This block is a reconfigurable datapath slice for symmetric-cipher primitives. It takes three 32-bit operands into a row of configurable bit cells. Each cell is a full adder built from two half adders whose carries are merged by an OR gate. A per-cell select code picks which internal node drives the cell outputs, so a cell can act as an XOR, AND or OR gate, or as a carry-save adder slice.

The first cell-row output goes through a permutation stage. This stage can pass the word unchanged, shift it left by a constant, rotate it left, or gather every output bit from a bit position taken from a table. The second word carries the carry-save carries, moved up one bit position. Its bit 0, which is free after that move, is driven by a 4-input lookup element indexed by the low nibble of the fourth operand.

Both words are captured in one 64-bit result register. The configuration is held in registers that a narrow write port loads. It controls the cell codes, the permutation mode and amount, the lookup truth table and the gather table.

Top module: `cs_cluster`

## Requirements
- R1: After a synchronous reset, both result words are zero and the configuration is set as follows: every cell in XOR mode, permutation mode pass, amount 0, lookup table all zeros, and gather entry i = i.
- R2: Cell code 0 (XOR) gives result_lo bit i = A[i]^B[i] in pass mode, and that cell adds no carry to result_hi.
- R3: Cell code 1 (AND) gives A[i]&B[i], and cell code 2 (OR) gives A[i]|B[i]. Neither adds a carry.
- R4: Cell code 3 (carry-save) gives low bit i = A[i]^B[i]^C[i] and high bit i+1 = majority(A[i],B[i],C[i]). The carry of bit 31 is dropped. With all cells in this mode, pass mode and a zero lookup table, result_lo + result_hi equals A+B+C modulo 2^32.
- R5: Each cell has its own code. Config address 0 holds cells 0..15 and address 1 holds cells 16..31, with cell k of a word in data bits [2k+1:2k].
- R6: Config address 2 sets the permutation stage: data bits [1:0] are the mode and bits [6:2] are the amount. Mode 0 passes the word. Mode 1 shifts it left by the amount with zero fill. Mode 2 rotates it left by the amount.
- R7: Mode 3 gathers bits: low output bit i = cell-row bit map[i]. Entry i is written at config address 32+i from data bits [4:0].
- R8: Data bits [31:16] at config address 2 form the lookup truth table. result_hi bit 0 = table[D[3:0]].
- R9: The result register loads on every rising edge with en high and holds its value with en low. Outputs therefore lag the inputs by one clock.
- R10: A config write is used from the edge after the one that stores it. Writes to addresses 3..31 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Result register load enable |
| op_a | input | 32 | Cell operand A |
| op_b | input | 32 | Cell operand B |
| op_c | input | 32 | Cell operand C (carry-save third input) |
| op_d | input | 32 | Lookup operand; bits [3:0] index the table |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| res_lo | output | 32 | Registered permuted cell-row word |
| res_hi | output | 32 | Registered carry word, bit 0 from the lookup |

## Verification
Random operands are applied under each uniform cell code. This shows whether the select stage picks the right internal node, since XOR, AND, OR and sum disagree on most random bit triples. All-ones operands in carry-save mode expose any loss or leak of the top carry, and an arithmetic sum check ties both words to A+B+C. A mixed code pattern shows whether the per-cell fields are decoded in the right positions. Shift and rotate are tried at amounts 0, 5 and 31, where a wrong wrap or fill shows up at once. A reversed gather table separates gathering from pass mode, and a parity truth table swept over D shows whether the lookup index is correct.

// File: rtl/cs_cluster_pkg.sv
package cs_cluster_pkg;
  typedef enum logic [1:0] {
    OP_XOR = 2'd0,
    OP_AND = 2'd1,
    OP_OR  = 2'd2,
    OP_CSA = 2'd3
  } cell_op_e;

  typedef enum logic [1:0] {
    PM_PASS = 2'd0,
    PM_SHL  = 2'd1,
    PM_ROTL = 2'd2,
    PM_MAP  = 2'd3
  } perm_mode_e;
endpackage

// File: rtl/cs_cell.sv
module cs_cell
  import cs_cluster_pkg::*;
(
  input  logic       a,
  input  logic       b,
  input  logic       c,
  input  logic [1:0] sel,
  output logic       o1,
  output logic       co
);
  logic x1, g1, s2, g2, cy;

  // two half adders and an OR gate on their carries
  assign x1 = a ^ b;
  assign g1 = a & b;
  assign s2 = x1 ^ c;
  assign g2 = x1 & c;
  assign cy = g1 | g2;

  always_comb begin
    o1 = x1;
    co = 1'b0;
    case (cell_op_e'(sel))
      OP_XOR: o1 = x1;
      OP_AND: o1 = g1;
      OP_OR:  o1 = x1 | g1;
      OP_CSA: begin
        o1 = s2;
        co = cy;
      end
      default: o1 = x1;
    endcase
  end
endmodule

// File: rtl/cs_cell_array.sv
module cs_cell_array
  import cs_cluster_pkg::*;
#(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic [W-1:0]   c,
  input  logic [2*W-1:0] sel,
  output logic [W-1:0]   o1,
  output logic [W-1:0]   o2
);
  logic [W-1:0] car;

  for (genvar i = 0; i < W; i++) begin : g_cell
    cs_cell u_cell (
      .a  (a[i]),
      .b  (b[i]),
      .c  (c[i]),
      .sel(sel[2*i +: 2]),
      .o1 (o1[i]),
      .co (car[i])
    );

    AST_CSA_WEIGHT: assert property (@(posedge clk) disable iff (rst)
      (sel[2*i +: 2] == OP_CSA) |->
        ({car[i], o1[i]} == (2'(a[i]) + 2'(b[i]) + 2'(c[i])))); // R4

    AST_LOGIC_NO_CARRY: assert property (@(posedge clk) disable iff (rst)
      (sel[2*i +: 2] != OP_CSA) |-> (car[i] == 1'b0)); // R2
  end

  // carries move one place up; the top carry is discarded
  assign o2 = {car[W-2:0], 1'b0};
endmodule

// File: rtl/cs_permute.sv
module cs_permute
  import cs_cluster_pkg::*;
#(
  parameter int W  = 32,
  localparam int SW = $clog2(W)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      mode,
  input  logic [SW-1:0]   amt,
  input  logic [W*SW-1:0] map,
  input  logic [W-1:0]    din,
  output logic [W-1:0]    dout
);
  logic [W-1:0]   gathered;
  logic [2*W-1:0] dbl;

  for (genvar i = 0; i < W; i++) begin : g_gather
    assign gathered[i] = din[map[i*SW +: SW]];
  end

  assign dbl = {din, din} << amt;

  always_comb begin
    case (perm_mode_e'(mode))
      PM_PASS: dout = din;
      PM_SHL:  dout = din << amt;
      PM_ROTL: dout = dbl[2*W-1:W];
      PM_MAP:  dout = gathered;
      default: dout = din;
    endcase
  end

  AST_ROT_KEEPS_ONES: assert property (@(posedge clk) disable iff (rst)
    (mode == PM_ROTL) |-> ($countones(dout) == $countones(din))); // R6

  AST_SHL_ZERO_FILL: assert property (@(posedge clk) disable iff (rst)
    (mode == PM_SHL) |-> ((dout & ~({W{1'b1}} << amt)) == '0)); // R6
endmodule

// File: rtl/cs_lut4.sv
module cs_lut4 #(
  parameter int N = 4,
  localparam int ENTRIES = 2**N
) (
  input  logic [ENTRIES-1:0] tab,
  input  logic [N-1:0]       idx,
  output logic               y
);
  assign y = tab[idx];
endmodule

// File: rtl/cs_cluster.sv
module cs_cluster
  import cs_cluster_pkg::*;
#(
  parameter int W      = 32,
  parameter int CW     = 32,
  parameter int LUT_IN = 4,
  localparam int SW        = $clog2(W),
  localparam int CAW       = $clog2(2*W),
  localparam int SEL_WORDS = (2*W + CW - 1) / CW,
  localparam int CTRL_ADDR = SEL_WORDS,
  localparam int MAP_BASE  = W,
  localparam int LUT_N     = 2**LUT_IN
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en,
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  input  logic [W-1:0]   op_c,
  input  logic [W-1:0]   op_d,
  input  logic           cfg_we,
  input  logic [CAW-1:0] cfg_addr,
  input  logic [CW-1:0]  cfg_wdata,
  output logic [W-1:0]   res_lo,
  output logic [W-1:0]   res_hi
);
  logic [SEL_WORDS*CW-1:0] sel_q;
  logic [1:0]              mode_q;
  logic [SW-1:0]           amt_q;
  logic [LUT_N-1:0]        lut_q;
  logic [W*SW-1:0]         map_q;

  logic [W-1:0]   row_o1, row_o2, perm_o;
  logic           lut_y;
  logic [2*W-1:0] res_q;

  // cell select words
  for (genvar k = 0; k < SEL_WORDS; k++) begin : g_selw
    always_ff @(posedge clk) begin
      if (rst) sel_q[k*CW +: CW] <= '0;
      else if (cfg_we && cfg_addr == CAW'(k)) sel_q[k*CW +: CW] <= cfg_wdata;
    end
  end

  // permutation mode, amount and lookup table
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= PM_PASS;
      amt_q  <= '0;
      lut_q  <= '0;
    end else if (cfg_we && cfg_addr == CAW'(CTRL_ADDR)) begin
      mode_q <= cfg_wdata[1:0];
      amt_q  <= cfg_wdata[2 +: SW];
      lut_q  <= cfg_wdata[CW-1 -: LUT_N];
    end
  end

  // gather table, identity after reset
  for (genvar j = 0; j < W; j++) begin : g_map
    always_ff @(posedge clk) begin
      if (rst) map_q[j*SW +: SW] <= SW'(j);
      else if (cfg_we && cfg_addr == CAW'(MAP_BASE + j)) map_q[j*SW +: SW] <= cfg_wdata[SW-1:0];
    end
  end

  cs_cell_array #(.W(W)) u_array (
    .clk(clk),
    .rst(rst),
    .a  (op_a),
    .b  (op_b),
    .c  (op_c),
    .sel(sel_q[2*W-1:0]),
    .o1 (row_o1),
    .o2 (row_o2)
  );

  cs_permute #(.W(W)) u_perm (
    .clk (clk),
    .rst (rst),
    .mode(mode_q),
    .amt (amt_q),
    .map (map_q),
    .din (row_o1),
    .dout(perm_o)
  );

  cs_lut4 #(.N(LUT_IN)) u_lut (
    .tab(lut_q),
    .idx(op_d[LUT_IN-1:0]),
    .y  (lut_y)
  );

  always_ff @(posedge clk) begin
    if (rst) res_q <= '0;
    else if (en) res_q <= {row_o2[W-1:1], lut_y, perm_o};
  end

  assign res_lo = res_q[W-1:0];
  assign res_hi = res_q[2*W-1:W];

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(res_q)); // R9
endmodule

// File: tb/cs_cluster_bench.sv
module cs_cluster_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic [31:0] op_a = '0, op_b = '0, op_c = '0, op_d = '0;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] res_lo, res_hi;

  int    n_vec = 0;
  int    n_bad = 0;
  int    cyc = 0;
  bit    done = 1'b0;
  string tag = "R1";

  // reference model state
  int          sel_m[32];
  int          map_m[32];
  int          mode_m, amt_m;
  logic [15:0] lut_m;
  logic [31:0] exp_lo = '0, exp_hi = '0;

  always #5 clk = ~clk;

  cs_cluster u_cs_cluster (
    .clk(clk), .rst(rst), .en(en),
    .op_a(op_a), .op_b(op_b), .op_c(op_c), .op_d(op_d),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .res_lo(res_lo), .res_hi(res_hi)
  );

  function automatic logic [31:0] permute(input logic [31:0] x);
    logic [31:0] r;
    case (mode_m)
      1: r = x << amt_m;
      2: r = (amt_m == 0) ? x : ((x << amt_m) | (x >> (32 - amt_m)));
      3: for (int i = 0; i < 32; i++) r[i] = x[map_m[i]];
      default: r = x;
    endcase
    return r;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 32; i++) begin sel_m[i] = 0; map_m[i] = i; end
      mode_m = 0; amt_m = 0; lut_m = '0;
      exp_lo = '0; exp_hi = '0;
    end else begin
      if (en) begin
        logic [31:0] lo, hi;
        lo = '0; hi = '0;
        for (int i = 0; i < 32; i++) begin
          int cnt;
          cnt = int'(op_a[i]) + int'(op_b[i]) + int'(op_c[i]);
          case (sel_m[i])
            0: lo[i] = op_a[i] ^ op_b[i];
            1: lo[i] = op_a[i] & op_b[i];
            2: lo[i] = op_a[i] | op_b[i];
            default: begin
              lo[i] = cnt[0];
              if (i < 31) hi[i+1] = (cnt >= 2);
            end
          endcase
        end
        hi[0] = lut_m[op_d[3:0]];
        exp_lo = permute(lo);
        exp_hi = hi;
      end
      if (cfg_we) begin
        if (cfg_addr < 2) begin
          for (int k = 0; k < 16; k++) sel_m[int'(cfg_addr)*16 + k] = int'(cfg_wdata[2*k +: 2]);
        end else if (cfg_addr == 2) begin
          mode_m = int'(cfg_wdata[1:0]);
          amt_m  = int'(cfg_wdata[6:2]);
          lut_m  = cfg_wdata[31:16];
        end else if (cfg_addr >= 32) begin
          map_m[int'(cfg_addr) - 32] = int'(cfg_wdata[4:0]);
        end
      end
    end
  end

  // compare on every falling edge, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (!done) begin
      n_vec++;
      if (res_lo !== exp_lo || res_hi !== exp_hi) begin
        n_bad++;
        $display("FAIL %s: got hi=%h lo=%h expected hi=%h lo=%h", tag, res_hi, res_lo, exp_hi, exp_lo);
      end
    end
    if (cyc > 20000 && !done) begin
      n_bad++;
      $display("FAIL watchdog: got running expected finished");
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  task automatic wr(input logic [5:0] addr, input logic [31:0] data);
    cfg_we = 1'b1; cfg_addr = addr; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run(input int n, input int kind);
    for (int i = 0; i < n; i++) begin
      case (kind)
        1: begin op_a = '1; op_b = '1; op_c = '1; end
        2: begin op_a = '0; op_b = '0; op_c = '0; end
        default: begin op_a = $urandom; op_b = $urandom; op_c = $urandom; end
      endcase
      op_d = $urandom;
      @(negedge clk);
    end
  endtask

  task automatic sum_check(input logic [31:0] a, input logic [31:0] b, input logic [31:0] c);
    logic [31:0] s;
    op_a = a; op_b = b; op_c = c; op_d = '0;
    @(negedge clk);
    #1;
    s = a + b + c;
    n_vec++;
    if (res_lo + res_hi !== s) begin
      n_bad++;
      $display("FAIL R4 sum: got %h expected %h", res_lo + res_hi, s);
    end
  endtask

  initial begin
    tag = "R1";
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    en = 1'b1;
    tag = "R2"; run(8, 0);
    tag = "R3"; wr(6'd0, 32'h5555_5555); wr(6'd1, 32'h5555_5555); run(8, 0);
    wr(6'd0, 32'hAAAA_AAAA); wr(6'd1, 32'hAAAA_AAAA); run(8, 0);
    tag = "R4"; wr(6'd0, 32'hFFFF_FFFF); wr(6'd1, 32'hFFFF_FFFF);
    run(3, 1); run(2, 2); run(8, 0);
    sum_check(32'hFFFF_FFFF, 32'h0000_0001, 32'h8000_0000);
    sum_check(32'h1234_5678, 32'h9ABC_DEF0, 32'h0F0F_F0F0);
    tag = "R5"; wr(6'd0, 32'h1B1B_E4E4); wr(6'd1, 32'h3210_C6C6); run(10, 0);
    tag = "R6"; wr(6'd2, {16'h0, 9'h0, 5'd0, 2'd1}); run(3, 0);
    wr(6'd2, {16'h0, 9'h0, 5'd5, 2'd1}); run(4, 0);
    wr(6'd2, {16'h0, 9'h0, 5'd31, 2'd1}); run(4, 0);
    wr(6'd2, {16'h0, 9'h0, 5'd0, 2'd2}); run(3, 0);
    wr(6'd2, {16'h0, 9'h0, 5'd5, 2'd2}); run(4, 0);
    wr(6'd2, {16'h0, 9'h0, 5'd31, 2'd2}); run(4, 0);
    tag = "R7";
    for (int i = 0; i < 32; i++) wr(6'(32 + i), 32'(31 - i));
    wr(6'd2, {16'h0, 9'h0, 5'd0, 2'd3}); run(6, 0);
    wr(6'd32, 32'd7); run(4, 0);
    tag = "R8"; wr(6'd2, {16'h6996, 9'h0, 5'd0, 2'd0});
    for (int i = 0; i < 16; i++) begin
      op_a = $urandom; op_b = $urandom; op_c = $urandom; op_d = 32'(i);
      @(negedge clk);
    end
    tag = "R9"; en = 1'b0; run(6, 0); en = 1'b1; run(3, 0);
    tag = "R10";
    wr(6'd5, 32'hFFFF_FFFF); wr(6'd17, 32'h0000_0003); wr(6'd31, 32'h1234_5678); run(4, 0);
    wr(6'd0, 32'h0); run(4, 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule